// File: doc/BRIEF.md
# Tearing-Effect Sync Pulse Discriminator

A display panel reports its refresh position on one tearing-effect wire that carries both line and frame sync pulses, told apart only by how long each pulse lasts. This block brings that wire into the core clock domain and measures every active pulse in clock ticks. It then sorts each pulse into one of three classes: a frame (vertical) sync, a line (horizontal) sync, or noise.

The result releases a pending frame transfer through a one-cycle start trigger. There are two ways to fire it. In frame mode the trigger follows every frame sync. In line mode the block counts line syncs from the latest frame sync and fires once, when the count reaches a programmed line. Line mode is used to start the write-out below the panel's scan position. A separate active level can be chosen for each of the two classes. A mode value of zero leaves the start to software alone, and the block stays silent.

Top module: `te_pulse_trigger`

## Requirements
- R1: `te_pin` passes through a two-flop synchroniser. For a pulse that ends a frame sync in frame mode, `trig_start` rises on the third rising clock edge counting from, and including, the first edge that samples `te_pin` at its inactive level.
- R2: A pulse's width is the number of consecutive rising edges at which the synchronised pin is active. The width counter saturates at 2^CNT_W-1. A width of at least `vs_width` is a frame sync. A width of at least `hs_width` and below `vs_width` is a line sync. A shorter pulse has no effect.
- R3: `hs_active_high` sets the level measured for line syncs and `vs_active_high` sets the level measured for frame syncs (1 = high is active, 0 = low is active). A pulse at the level that is inactive for a class never counts as that class.
- R4: `mode` encoding: 0 = software start only (never fires), 1 = fire on every frame sync, 2 = line mode, 3 = reserved (never fires).
- R5: In line mode, a frame sync clears the line count and a line sync increments it. The trigger fires on the line sync that makes the count equal `line_target`. When `line_target` is 0, the trigger fires on the frame sync itself.
- R6: In line mode the trigger fires at most once per frame. Only a new frame sync re-arms it.
- R7: While `enable` is low, `trig_start` stays low.
- R8: `trig_start` is never high for two consecutive cycles.
- R9: `line_target` is 11 bits wide, so the target can be any line up to 2047. The line count saturates at 2047.
- R10: After reset, `trig_start` is low and line mode is disarmed: line syncs that arrive before the first frame sync never fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| te_pin | input | 1 | Asynchronous tearing-effect input from the panel |
| enable | input | 1 | Allows the trigger to fire |
| mode | input | 2 | Trigger mode (R4) |
| hs_width | input | CNT_W | Minimum line-sync width in ticks |
| vs_width | input | CNT_W | Minimum frame-sync width in ticks |
| hs_active_high | input | 1 | Active level for line-sync measurement |
| vs_active_high | input | 1 | Active level for frame-sync measurement |
| line_target | input | LINE_W | Line on which line mode fires |
| trig_start | output | 1 | One-cycle start trigger |

## Verification
Two functions can fall in the same cycle: the frame sync that clears and re-arms the line counter, and the firing decision itself. The first case is line mode with a target of 0, where the bench checks that a single frame sync both resets the count and fires exactly once. The second case is a frame sync arriving right after a line-mode trigger, where the bench checks that the next frame fires again at its target and not earlier. Every outcome is judged by counting trigger pulses against an expected count, and that count is worked out from the pulse widths and line numbers the bench sent.

// File: rtl/te_disc_pkg.sv
package te_disc_pkg;

    localparam int LINE_BITS_DEF = 11;
    localparam int TICK_BITS_DEF = 6;

    typedef enum logic [1:0] {
        TRIG_SOFT  = 2'd0,
        TRIG_FRAME = 2'd1,
        TRIG_LINE  = 2'd2,
        TRIG_RSVD  = 2'd3
    } trig_mode_e;

    typedef struct packed {
        logic line_sync;
        logic frame_sync;
    } sync_evt_t;

    // measured level is active when it matches the selected polarity
    function automatic logic level_active(input logic level, input logic hi_active);
        return hi_active ? level : ~level;
    endfunction

endpackage

// File: rtl/te_sync2.sv
module te_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else if (i == 0) chain[i] <= din;
                else chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/te_width_meter.sv
module te_width_meter
    import te_disc_pkg::*;
#(
    parameter int CNT_W = TICK_BITS_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             level,
    input  logic             hi_active,
    output logic             done,
    output logic [CNT_W-1:0] width
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             active;
    logic             was_active;
    logic [CNT_W-1:0] run_len;

    assign active = level_active(level, hi_active);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len    <= '0;
            was_active <= 1'b0;
        end else begin
            was_active <= active;
            if (active) run_len <= (run_len == CNT_MAX) ? run_len : run_len + 1'b1;
            else        run_len <= '0;
        end
    end

    assign done  = was_active & ~active;
    assign width = run_len;

    assert_idle_clear_R2: assert property (@(posedge clk) disable iff (rst)
        !active |=> (run_len == '0));
    assert_saturate_R2: assert property (@(posedge clk) disable iff (rst)
        (active && run_len == CNT_MAX) |=> (run_len == CNT_MAX));
endmodule

// File: rtl/te_line_trigger.sv
module te_line_trigger
    import te_disc_pkg::*;
#(
    parameter int LINE_W = LINE_BITS_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  sync_evt_t         evt,
    input  trig_mode_e        mode,
    input  logic              enable,
    input  logic [LINE_W-1:0] target,
    output logic              trig
);
    localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

    logic [LINE_W-1:0] line_cnt;
    logic [LINE_W-1:0] line_nxt;
    logic              armed;

    assign line_nxt = (line_cnt == LINE_MAX) ? line_cnt : line_cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_cnt <= '0;
            armed    <= 1'b0;
            trig     <= 1'b0;
        end else begin
            trig <= 1'b0;
            if (evt.frame_sync) begin
                line_cnt <= '0;
                armed    <= 1'b1;
                if (enable && mode == TRIG_FRAME) begin
                    trig <= 1'b1;
                end else if (enable && mode == TRIG_LINE && target == '0) begin
                    trig  <= 1'b1;
                    armed <= 1'b0;
                end
            end else if (evt.line_sync) begin
                line_cnt <= line_nxt;
                if (enable && armed && mode == TRIG_LINE && line_nxt == target) begin
                    trig  <= 1'b1;
                    armed <= 1'b0;
                end
            end
        end
    end

    assert_single_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        trig |=> !trig);
    assert_enable_gate_R7: assert property (@(posedge clk) disable iff (rst)
        trig |-> $past(enable));
    assert_mode_gate_R4: assert property (@(posedge clk) disable iff (rst)
        trig |-> ($past(mode) == TRIG_FRAME || $past(mode) == TRIG_LINE));
    assert_frame_clear_R5: assert property (@(posedge clk) disable iff (rst)
        evt.frame_sync |=> (line_cnt == '0));
    assert_once_per_frame_R6: assert property (@(posedge clk) disable iff (rst)
        (trig && $past(mode) == TRIG_LINE) |-> !armed);
    assert_exclusive_class_R2: assert property (@(posedge clk) disable iff (rst)
        !(evt.frame_sync && evt.line_sync));
    assert_line_saturate_R9: assert property (@(posedge clk) disable iff (rst)
        (line_cnt == LINE_MAX && evt.line_sync && !evt.frame_sync) |=> (line_cnt == LINE_MAX));
endmodule

// File: rtl/te_pulse_trigger.sv
module te_pulse_trigger
    import te_disc_pkg::*;
#(
    parameter int CNT_W  = TICK_BITS_DEF,
    parameter int LINE_W = LINE_BITS_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              te_pin,
    input  logic              enable,
    input  logic [1:0]        mode,
    input  logic [CNT_W-1:0]  hs_width,
    input  logic [CNT_W-1:0]  vs_width,
    input  logic              hs_active_high,
    input  logic              vs_active_high,
    input  logic [LINE_W-1:0] line_target,
    output logic              trig_start
);
    localparam int N_CLASS = 2;
    localparam int IDX_HS  = 0;
    localparam int IDX_VS  = 1;

    logic                  te_sync;
    logic [N_CLASS-1:0]    pol_sel;
    logic [N_CLASS-1:0]    pulse_done;
    logic [CNT_W-1:0]      pulse_len [N_CLASS];
    sync_evt_t             evt;

    assign pol_sel[IDX_HS] = hs_active_high;
    assign pol_sel[IDX_VS] = vs_active_high;

    te_sync2 #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (te_pin),
        .dout (te_sync)
    );

    generate
        for (genvar c = 0; c < N_CLASS; c++) begin : g_meter
            te_width_meter #(.CNT_W(CNT_W)) u_meter (
                .clk       (clk),
                .rst       (rst),
                .level     (te_sync),
                .hi_active (pol_sel[c]),
                .done      (pulse_done[c]),
                .width     (pulse_len[c])
            );
        end
    endgenerate

    always_comb begin
        evt.frame_sync = pulse_done[IDX_VS] && (pulse_len[IDX_VS] >= vs_width);
        evt.line_sync  = pulse_done[IDX_HS] && (pulse_len[IDX_HS] >= hs_width)
                         && (pulse_len[IDX_HS] < vs_width);
    end

    te_line_trigger #(.LINE_W(LINE_W)) u_trig (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .mode   (trig_mode_e'(mode)),
        .enable (enable),
        .target (line_target),
        .trig   (trig_start)
    );
endmodule

// File: tb/test_te_pulse_trigger.sv
module test_te_pulse_trigger;
    localparam int CNT_W  = 6;
    localparam int LINE_W = 11;
    localparam int GAP    = 6;
    localparam int HSW    = 3;
    localparam int VSW    = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              te_pin = 1'b0;
    logic              enable = 1'b0;
    logic [1:0]        mode = 2'd0;
    logic [CNT_W-1:0]  hs_width = CNT_W'(HSW);
    logic [CNT_W-1:0]  vs_width = CNT_W'(VSW);
    logic              hs_active_high = 1'b1;
    logic              vs_active_high = 1'b1;
    logic [LINE_W-1:0] line_target = '0;
    logic              trig_start;

    int  vectors = 0;
    int  miscompares = 0;
    int  trig_cnt = 0;
    int  doubled = 0;
    int  cycles = 0;
    bit  act_lvl = 1'b1;
    bit  prev_trig = 1'b0;
    bit  finished = 1'b0;

    te_pulse_trigger #(.CNT_W(CNT_W), .LINE_W(LINE_W)) i_te_pulse_trigger (
        .clk(clk), .rst(rst), .te_pin(te_pin), .enable(enable), .mode(mode),
        .hs_width(hs_width), .vs_width(vs_width), .hs_active_high(hs_active_high),
        .vs_active_high(vs_active_high), .line_target(line_target),
        .trig_start(trig_start)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (trig_start) trig_cnt++;
        if (trig_start && prev_trig) doubled++;
        prev_trig = trig_start;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !finished) begin
            finished = 1'b1;
            miscompares++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse(input int p);
        @(negedge clk) te_pin = act_lvl;
        repeat (p) @(negedge clk);
        te_pin = ~act_lvl;
        repeat (GAP) @(negedge clk);
    endtask

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 trigger low after reset", int'(trig_start), 0);

        // R10: line syncs before any frame sync never fire
        enable = 1'b1; mode = 2'd2; line_target = 11'd1;
        base = trig_cnt;
        for (int k = 0; k < 3; k++) pulse(HSW);
        chk("R10 disarmed until first frame sync", trig_cnt - base, 0);

        // R1: exact latency in frame mode
        mode = 2'd1;
        @(negedge clk) te_pin = 1'b1;
        repeat (8) @(negedge clk);
        te_pin = 1'b0;
        @(negedge clk); chk("R1 latency edge 1", int'(trig_start), 0);
        @(negedge clk); chk("R1 latency edge 2", int'(trig_start), 0);
        @(negedge clk); chk("R1 latency edge 3", int'(trig_start), 1);
        @(negedge clk); chk("R8 single cycle", int'(trig_start), 0);
        repeat (GAP) @(negedge clk);

        // R2: width sweep in frame mode (fires only on frame syncs)
        for (int p = 1; p <= 9; p++) begin
            base = trig_cnt;
            pulse(p);
            chk($sformatf("R2 frame class width %0d", p), trig_cnt - base, (p >= VSW) ? 1 : 0);
        end
        base = trig_cnt;
        pulse(70);
        chk("R2 saturated long pulse is frame sync", trig_cnt - base, 1);

        // R2: width sweep in line mode target 1 (fires only on line syncs)
        mode = 2'd2; line_target = 11'd1;
        for (int p = 1; p <= 9; p++) begin
            pulse(VSW + 2);
            base = trig_cnt;
            pulse(p);
            chk($sformatf("R2 line class width %0d", p), trig_cnt - base,
                (p >= HSW && p < VSW) ? 1 : 0);
        end

        // R5/R6: target sweep, cumulative count after each line
        for (int t = 0; t <= 5; t++) begin
            line_target = LINE_W'(t);
            base = trig_cnt;
            pulse(VSW);
            chk($sformatf("R5 target %0d after frame sync", t), trig_cnt - base, (t == 0) ? 1 : 0);
            for (int k = 1; k <= 6; k++) begin
                pulse(HSW + 1);
                chk($sformatf("R6 target %0d after line %0d", t, k), trig_cnt - base,
                    (k >= t) ? 1 : 0);
            end
        end
        // R6: new frame re-arms
        line_target = 11'd2;
        base = trig_cnt;
        pulse(VSW); pulse(HSW);
        chk("R6 rearm not early", trig_cnt - base, 0);
        pulse(HSW);
        chk("R6 rearm fires at target", trig_cnt - base, 1);

        // R4: modes 0 and 3 never fire
        for (int m = 0; m < 4; m += 3) begin
            mode = 2'(m); line_target = 11'd1;
            base = trig_cnt;
            pulse(VSW); pulse(HSW); pulse(VSW + 3);
            chk($sformatf("R4 mode %0d silent", m), trig_cnt - base, 0);
        end

        // R7: enable low blocks both modes
        enable = 1'b0;
        mode = 2'd1; base = trig_cnt; pulse(VSW);
        chk("R7 frame mode disabled", trig_cnt - base, 0);
        mode = 2'd2; line_target = 11'd1; base = trig_cnt; pulse(VSW); pulse(HSW);
        chk("R7 line mode disabled", trig_cnt - base, 0);
        enable = 1'b1;

        // R3: both classes low-active, idle high
        @(negedge clk) begin te_pin = 1'b1; hs_active_high = 1'b0; vs_active_high = 1'b0; end
        act_lvl = 1'b0;
        repeat (10) @(negedge clk);
        line_target = 11'd2; base = trig_cnt;
        pulse(VSW); pulse(HSW);
        chk("R3 low-active before target", trig_cnt - base, 0);
        pulse(HSW + 2);
        chk("R3 low-active line target", trig_cnt - base, 1);

        // R3: line class inverted, frame class high: high pulses of line width ignored
        @(negedge clk) begin te_pin = 1'b0; hs_active_high = 1'b1; vs_active_high = 1'b1; end
        act_lvl = 1'b1;
        repeat (10) @(negedge clk);
        line_target = 11'd1;
        pulse(VSW);
        hs_active_high = 1'b0;
        repeat (20) @(negedge clk);
        base = trig_cnt;
        pulse(HSW + 1);
        chk("R3 wrong-level pulse not a line", trig_cnt - base, 0);
        hs_active_high = 1'b1;
        repeat (10) @(negedge clk);

        // R9: target 2047 and saturation
        line_target = 11'd2047;
        base = trig_cnt;
        pulse(VSW);
        for (int k = 1; k < 2047; k++) pulse(HSW);
        chk("R9 no fire before line 2047", trig_cnt - base, 0);
        pulse(HSW);
        chk("R9 fires at line 2047", trig_cnt - base, 1);
        pulse(HSW); pulse(HSW);
        chk("R9 saturated count no refire", trig_cnt - base, 1);

        chk("R8 never two cycles high", doubled, 0);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule